// File: doc/BRIEF.md
# Dispatch Group Throttle

This block sits at the dispatch stage of an out-of-order core. It decides whether the instruction presented this clock may enter the backend. It also meters how many micro-ops enter within one dispatch cycle. A dispatch cycle is the span between two `grp_next` pulses. Each such cycle opens with a budget of `DISP_WIDTH` micro-ops. Instructions are offered one per clock and each one spends part of that budget.

An instruction with more micro-ops than the dispatch width can start only while the budget is still full. Its excess is held in a carry-over register, and that carry-over eats into the budgets of the dispatch cycles that follow.

Readiness comes from outside the block, as one flag per resource. There are five resources: retire slots, rename registers, scheduler entries, load-queue entries and store-queue entries. When a valid request is refused, the first failing reason in priority order is charged to its own saturating counter. The reasons in priority order are group width, retire, rename, scheduler, load and store.

The budget tracker runs a four-state machine:

| State | Condition |
|-------|-----------|
| FRESH | budget equals the width and carry-over is zero |
| PART | budget is between zero and the width and carry-over is zero |
| SPENT | budget is zero and carry-over is zero |
| OWED | budget is zero and carry-over is non-zero |

Its transitions are as follows:

- **fill**: FRESH to PART, on an accept of fewer micro-ops than the width.
- **close**: FRESH or PART to SPENT, on an accept that exactly uses the budget that is left.
- **overrun**: FRESH to OWED, on an accept wider than the width.
- **renew**: PART or SPENT to FRESH, on a rollover.
- **repay**: OWED to OWED, SPENT or PART on a rollover, depending on whether the carry-over is above, equal to or below the width.

Top module: `disp_throttle`

## Requirements
- R1: A synchronous active-high reset makes the budget equal to the width and clears the carry-over and all six stall counters. The first request after reset with `req_uops` equal to `DISP_WIDTH` and all resources ready is therefore accepted.
- R2: A request fits the group when `req_uops` is no greater than the remaining budget, or when the remaining budget still equals `DISP_WIDTH`. A request that does not fit is refused.
- R3: An accept whose micro-op count is within the budget lowers the budget by that count, so that several instructions can share one dispatch cycle. A count of zero leaves the budget unchanged.
- R4: An accept whose count exceeds the budget sets the budget to zero and adds the excess to the carry-over.
- R5: On a `grp_next` clock the budget becomes `DISP_WIDTH` minus the carry-over, floored at zero. In the same clock the carry-over drops by `DISP_WIDTH`, also floored at zero.
- R6: `accept` is high only when the request fits and `retire_ok`, `rename_ok`, `sched_ok`, `load_ok` and `store_ok` are all high.
- R7: A refused valid request increments exactly one counter: the one for the first failing reason in the order group, retire, rename, scheduler, load, store. It raises `stall_group`, `stall_retire`, `stall_rename`, `stall_sched`, `stall_load` or `stall_store` respectively, one clock after the request.
- R8: Each stall counter stops at its all-ones value instead of wrapping.
- R9: When `req_valid` is low, or `grp_next` is high, there is no accept, no budget change from the request, and no counter increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grp_next | input | 1 | Starts a new dispatch cycle (budget rollover) |
| req_valid | input | 1 | An instruction is offered this clock |
| req_uops | input | UOP_W | Micro-op count of the offered instruction |
| retire_ok | input | 1 | Enough retire slots for the instruction |
| rename_ok | input | 1 | Enough rename registers for its destinations |
| sched_ok | input | 1 | Enough scheduler entries |
| load_ok | input | 1 | Enough load-queue entries |
| store_ok | input | 1 | Enough store-queue entries |
| accept | output | 1 | The offered instruction dispatches this clock |
| stall_group | output | CNT_W | Refusals due to the group-width rule |
| stall_retire | output | CNT_W | Refusals due to missing retire slots |
| stall_rename | output | CNT_W | Refusals due to missing rename registers |
| stall_sched | output | CNT_W | Refusals due to a full scheduler |
| stall_load | output | CNT_W | Refusals due to a full load queue |
| stall_store | output | CNT_W | Refusals due to a full store queue |

## Verification
The bench builds the block with a width of 4, 4-bit micro-op counts and 3-bit counters. The 4-bit counts allow instructions of 8 and 9 micro-ops. These drive the carry-over past, and exactly onto, the width, which exercises each branch of the repay transition. The 3-bit counters saturate at 7 after a handful of refusals, so the saturation rule is reached in a short directed run. Combinations with several resource flags low confirm that only the highest-priority reason is charged.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        GB_FRESH,
        GB_PART,
        GB_SPENT,
        GB_OWED
    } gb_state_e;

    localparam int NUM_CAUSE = 6;
    localparam int CZ_GROUP  = 0;
    localparam int CZ_RETIRE = 1;
    localparam int CZ_RENAME = 2;
    localparam int CZ_SCHED  = 3;
    localparam int CZ_LOAD   = 4;
    localparam int CZ_STORE  = 5;

endpackage

// File: rtl/grp_budget.sv
module grp_budget
    import disp_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int UOP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll,
    input  logic             take,
    input  logic [UOP_W-1:0] uops,
    output logic             fits
);
    localparam int BW = $clog2(WIDTH + 1);
    localparam int XW = ((UOP_W > BW) ? UOP_W : BW) + 1;

    gb_state_e        state_q, state_n;
    logic [BW-1:0]    avail_q, avail_n;
    logic [UOP_W-1:0] carry_q, carry_n;
    logic [XW-1:0]    uops_x, avail_x, carry_x, wid_x;

    assign uops_x  = XW'(uops);
    assign avail_x = XW'(avail_q);
    assign carry_x = XW'(carry_q);
    assign wid_x   = XW'(WIDTH);

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GB_FRESH;
            avail_q <= BW'(WIDTH);
            carry_q <= '0;
        end else begin
            state_q <= state_n;
            avail_q <= avail_n;
            carry_q <= carry_n;
        end
    end

    // Budget and carry-over arithmetic
    always_comb begin
        avail_n = avail_q;
        carry_n = carry_q;
        if (roll) begin
            if (carry_x >= wid_x) begin
                avail_n = '0;
                carry_n = UOP_W'(carry_x - wid_x);
            end else begin
                avail_n = BW'(wid_x - carry_x);
                carry_n = '0;
            end
        end else if (take) begin
            if (uops_x <= avail_x) begin
                avail_n = BW'(avail_x - uops_x);
            end else begin
                avail_n = '0;
                carry_n = UOP_W'(carry_x + uops_x - avail_x);
            end
        end
    end

    // Next-state process: named transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            GB_FRESH: begin
                if (take && uops_x != '0) begin
                    if (uops_x < wid_x)       state_n = GB_PART;   // fill
                    else if (uops_x == wid_x) state_n = GB_SPENT;  // close
                    else                      state_n = GB_OWED;   // overrun
                end
            end
            GB_PART: begin
                if (roll)                                state_n = GB_FRESH; // renew
                else if (take && uops_x == avail_x)      state_n = GB_SPENT; // close
            end
            GB_SPENT: begin
                if (roll) state_n = GB_FRESH;                                // renew
            end
            GB_OWED: begin
                if (roll) begin                                              // repay
                    if (carry_x > wid_x)       state_n = GB_OWED;
                    else if (carry_x == wid_x) state_n = GB_SPENT;
                    else                       state_n = GB_PART;
                end
            end
            default: state_n = GB_FRESH;
        endcase
    end

    // Output process
    always_comb begin
        fits = (uops_x <= avail_x) || (avail_q == BW'(WIDTH));
    end

    p_fresh_full_r1: assert property (@(posedge clk) disable iff (rst)
        state_q == GB_FRESH |-> (avail_q == BW'(WIDTH) && carry_q == '0));

    p_part_range_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == GB_PART |-> (avail_q != '0 && avail_q != BW'(WIDTH) && carry_q == '0));

    p_owed_debt_r4: assert property (@(posedge clk) disable iff (rst)
        state_q == GB_OWED |-> (avail_q == '0 && carry_q != '0));

    p_roll_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (roll && carry_x >= wid_x) |=> avail_q == '0);

endmodule

// File: rtl/stall_pick.sv
module stall_pick
    import disp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 want,
    input  logic                 fits,
    input  logic                 retire_ok,
    input  logic                 rename_ok,
    input  logic                 sched_ok,
    input  logic                 load_ok,
    input  logic                 store_ok,
    output logic                 grant,
    output logic [NUM_CAUSE-1:0] cause
);
    logic [NUM_CAUSE-1:0] fail;
    logic                 taken;

    // Index order is the priority order: group, retire, rename, sched, load, store
    assign fail = {!store_ok, !load_ok, !sched_ok, !rename_ok, !retire_ok, !fits};

    always_comb begin
        cause = '0;
        taken = 1'b0;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            if (want && fail[i] && !taken) begin
                cause[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        grant = want && (fail == '0);
    end

    p_one_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause));

    p_grant_clean_r6: assert property (@(posedge clk) disable iff (rst)
        grant |-> (fits && retire_ok && rename_ok && sched_ok && load_ok && store_ok));

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (inc && cnt_q != '1)
            cnt_q <= cnt_q + W'(1);
    end

    assign count = cnt_q;

    p_hold_max_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q == '1 |=> cnt_q == '1);

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q != '1) |=> cnt_q != '0);

endmodule

// File: rtl/disp_throttle.sv
module disp_throttle
    import disp_pkg::*;
#(
    parameter int DISP_WIDTH = 4,
    parameter int UOP_W      = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_next,
    input  logic             req_valid,
    input  logic [UOP_W-1:0] req_uops,
    input  logic             retire_ok,
    input  logic             rename_ok,
    input  logic             sched_ok,
    input  logic             load_ok,
    input  logic             store_ok,
    output logic             accept,
    output logic [CNT_W-1:0] stall_group,
    output logic [CNT_W-1:0] stall_retire,
    output logic [CNT_W-1:0] stall_rename,
    output logic [CNT_W-1:0] stall_sched,
    output logic [CNT_W-1:0] stall_load,
    output logic [CNT_W-1:0] stall_store
);
    logic                 want;
    logic                 fits;
    logic                 grant;
    logic [NUM_CAUSE-1:0] cause;
    logic [CNT_W-1:0]     cnt [NUM_CAUSE];

    assign want = req_valid && !grp_next;

    grp_budget #(
        .WIDTH (DISP_WIDTH),
        .UOP_W (UOP_W)
    ) u_budget (
        .clk  (clk),
        .rst  (rst),
        .roll (grp_next),
        .take (grant),
        .uops (req_uops),
        .fits (fits)
    );

    stall_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .fits      (fits),
        .retire_ok (retire_ok),
        .rename_ok (rename_ok),
        .sched_ok  (sched_ok),
        .load_ok   (load_ok),
        .store_ok  (store_ok),
        .grant     (grant),
        .cause     (cause)
    );

    for (genvar k = 0; k < NUM_CAUSE; k++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cause[k]),
            .count (cnt[k])
        );
    end

    assign accept       = grant;
    assign stall_group  = cnt[CZ_GROUP];
    assign stall_retire = cnt[CZ_RETIRE];
    assign stall_rename = cnt[CZ_RENAME];
    assign stall_sched  = cnt[CZ_SCHED];
    assign stall_load   = cnt[CZ_LOAD];
    assign stall_store  = cnt[CZ_STORE];

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || grp_next) |-> (!accept && cause == '0));

    p_accept_nocount_r7: assert property (@(posedge clk) disable iff (rst)
        accept |-> cause == '0);

endmodule

// File: tb/disp_throttle_test.sv
module disp_throttle_test;
    localparam int W    = 4;
    localparam int UW   = 4;
    localparam int CW   = 3;
    localparam int CMAX = (1 << CW) - 1;
    localparam int NV   = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          grp_next = 1'b0;
    logic          req_valid = 1'b0;
    logic [UW-1:0] req_uops = '0;
    logic [4:0]    okv = 5'h1F;   // bit0 retire, 1 rename, 2 sched, 3 load, 4 store
    logic          accept;
    logic [CW-1:0] s_grp, s_ret, s_ren, s_sch, s_ld, s_st;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt [6];
    bit done = 1'b0;

    always #2 clk = ~clk;

    disp_throttle #(.DISP_WIDTH(W), .UOP_W(UW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .grp_next(grp_next), .req_valid(req_valid),
        .req_uops(req_uops), .retire_ok(okv[0]), .rename_ok(okv[1]),
        .sched_ok(okv[2]), .load_ok(okv[3]), .store_ok(okv[4]),
        .accept(accept), .stall_group(s_grp), .stall_retire(s_ret),
        .stall_rename(s_ren), .stall_sched(s_sch), .stall_load(s_ld),
        .stall_store(s_st)
    );

    // {grp_next, valid, uops, ok[4:0], exp_accept, cause(0 grp,1 ret,2 ren,3 sch,4 ld,5 st,7 none)}
    localparam logic [14:0] VECS [NV] = '{
        {1'b0,1'b1,4'd2,5'h1F,1'b1,3'd7},
        {1'b0,1'b1,4'd3,5'h1F,1'b0,3'd0},
        {1'b0,1'b1,4'd2,5'h1F,1'b1,3'd7},
        {1'b0,1'b1,4'd1,5'h1F,1'b0,3'd0},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd1,5'h1E,1'b0,3'd1},
        {1'b0,1'b1,4'd1,5'h1C,1'b0,3'd1},
        {1'b0,1'b1,4'd1,5'h1D,1'b0,3'd2},
        {1'b0,1'b1,4'd1,5'h1B,1'b0,3'd3},
        {1'b0,1'b1,4'd1,5'h17,1'b0,3'd4},
        {1'b0,1'b1,4'd1,5'h0F,1'b0,3'd5},
        {1'b0,1'b1,4'd1,5'h13,1'b0,3'd3},
        {1'b0,1'b0,4'd1,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd9,5'h1F,1'b1,3'd7},
        {1'b0,1'b1,4'd1,5'h1F,1'b0,3'd0},
        {1'b1,1'b1,4'd1,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd1,5'h1F,1'b0,3'd0},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd4,5'h1F,1'b0,3'd0},
        {1'b0,1'b1,4'd3,5'h1F,1'b1,3'd7},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd4,5'h00,1'b0,3'd1},
        {1'b0,1'b1,4'd4,5'h1F,1'b1,3'd7},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd0,5'h1F,1'b1,3'd7},
        {1'b0,1'b1,4'd8,5'h1F,1'b1,3'd7},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd1,5'h1F,1'b0,3'd0},
        {1'b1,1'b0,4'd0,5'h1F,1'b0,3'd7},
        {1'b0,1'b1,4'd1,5'h1F,1'b1,3'd7}
    };

    function automatic int act_cnt(int k);
        case (k)
            0: return int'(s_grp);
            1: return int'(s_ret);
            2: return int'(s_ren);
            3: return int'(s_sch);
            4: return int'(s_ld);
            default: return int'(s_st);
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_counters(string tag);
        for (int k = 0; k < 6; k++)
            check($sformatf("%s counter %0d", tag, k), act_cnt(k), exp_cnt[k]);
    endtask

    // drive at negedge, sample accept 1ns later, sample counters 1ns after posedge
    task automatic step(bit g, bit v, int u, logic [4:0] ok, bit eacc, int cz, string tag);
        @(negedge clk);
        grp_next  = g;
        req_valid = v;
        req_uops  = UW'(u);
        okv       = ok;
        #1;
        check({tag, " accept"}, int'(accept), int'(eacc));
        if (cz < 6 && exp_cnt[cz] < CMAX) exp_cnt[cz]++;
        @(posedge clk);
        #1;
        check_counters({tag, " R7"});
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) exp_cnt[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_counters("R1 reset");

        // Table walk: R2 fit, R3 sharing, R4 overrun, R5 rollover, R6/R7 causes, R9 idle
        for (int i = 0; i < NV; i++) begin
            logic [14:0] e;
            e = VECS[i];
            step(e[14], e[13], int'(e[12:9]), e[8:4], e[3], int'(e[2:0]),
                 $sformatf("R2 R3 R4 R5 R6 R9 vec%0d", i));
        end

        // R8: retire refusals until the counter saturates
        for (int j = 0; j < 6; j++)
            step(1'b0, 1'b1, 1, 5'h1E, 1'b0, 1, $sformatf("R8 sat%0d", j));
        check("R8 retire at max", int'(s_ret), CMAX);

        // R1: reset mid-run restores a full budget and clears counters
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        grp_next = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) exp_cnt[k] = 0;
        #1;
        check_counters("R1 after reset");
        step(1'b0, 1'b1, W, 5'h1F, 1'b1, 7, "R1 full budget");
        step(1'b0, 1'b1, 1, 5'h1F, 1'b0, 0, "R2 spent group");

        @(negedge clk);
        req_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule